// File: doc/BRIEF.md
# Suspend Wake-Up Release Sequencer

This block brings a programmable logic device back from its low-power suspend state in a fixed order. The device stays suspended while the wake input is low. Once wake is sampled high, the block counts edges of the wake-up timing clock. After a first programmable number of edges it frees the output pins, so they leave their suspend drive state and return to normal drive. After a second programmable number of edges it lifts the global write-protect lock on every clocked storage element. The outputs are always freed no later than the lock is lifted. If the configured lock delay is the shorter of the two, the lock release waits for the output release and an error flag is raised.

An option applies a one-cycle global set/reset just before the lock is lifted, so the clocked state starts from its initial values. Without that option, the state held through suspend is kept. The block samples the three configuration inputs on the first edge at which wake is seen high, so changing them during a sequence has no effect. If wake drops during a sequence, the sequence is aborted and the block returns to its suspend outputs. All ports are plain control and status pins: no data flows through the block, so it has no valid/ready handshake.

Top module: `wake_release_seq`

## Requirements
- R1: While reset is asserted, and after any edge at which wake_i is sampled low, out_rel_o, gwe_o, gsr_o, cfg_err_o and done_o are all low.
- R2: Counting edges from the first edge at which wake_i is sampled high as edge 1, out_rel_o goes high after edge N_out. N_out is the value of the out_dly_i field, where a value of 0 stands for 2^DLY_W edges (1024 by default, so the range is 1 to 1024).
- R3: With the set/reset option off, gwe_o goes high after edge max(N_wp, N_out). N_wp is decoded from wp_dly_i in the same way as N_out (0 stands for 2^DLY_W).
- R4: gwe_o is never high while out_rel_o is low.
- R5: cfg_err_o is high from edge 1 for as long as wake stays sampled high, whenever N_wp < N_out.
- R6: With the set/reset option on, gsr_o is high for exactly one cycle, after edge max(N_wp, N_out), and gwe_o goes high one edge later.
- R7: With the set/reset option off, gsr_o stays low for the whole sequence.
- R8: Sampling wake_i low in the middle of a sequence aborts it: all outputs fall after that edge. A later wake restarts the count from edge 1.
- R9: done_o is high exactly when out_rel_o and gwe_o are both high. It stays high until wake_i is sampled low.
- R10: out_dly_i, wp_dly_i and gsr_en_i are captured at edge 1. Changes to them later in the same sequence do not affect any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wake-up timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_i | input | 1 | Wake indication; low means suspended |
| out_dly_i | input | DLY_W | Output release delay field (0 means 2^DLY_W) |
| wp_dly_i | input | DLY_W | Write-protect release delay field (0 means 2^DLY_W) |
| gsr_en_i | input | 1 | Apply global set/reset before unlocking |
| out_rel_o | output | 1 | Output pins released to normal drive |
| gwe_o | output | 1 | Global write enable (write-protect lifted) |
| gsr_o | output | 1 | Global set/reset pulse |
| cfg_err_o | output | 1 | Lock delay configured shorter than output delay |
| done_o | output | 1 | Both releases complete |

## Verification
Output release and lock release can fall on the same edge. This happens whenever the two delays are equal, and also whenever a shorter lock delay is stretched to match the output delay. The bench reaches every such case by sweeping all pairs of delay fields, with the set/reset option both off and on, in a 4-bit configuration. In each cycle it compares both releases against thresholds it computes itself, and it checks that the write enable never leads the output release. In the same cycle as the output release it also judges the error flag, and with the option on it checks that the set/reset pulse sits in the single cycle between the output release and the write enable.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  localparam int unsigned DLY_W_DEF = 10;

  typedef struct packed {
    logic out_rel;
    logic gwe;
    logic gsr;
  } rel_flags_t;
endpackage

// File: rtl/wrs_dly_decode.sv
module wrs_dly_decode #(
  parameter int unsigned DLY_W = 10
) (
  input  logic [DLY_W-1:0] out_f,
  input  logic [DLY_W-1:0] wp_f,
  output logic [DLY_W:0]   out_n,
  output logic [DLY_W:0]   wp_eff,
  output logic             err
);
  localparam int unsigned NW = DLY_W + 1;
  localparam logic [NW-1:0] FULL = NW'(1) << DLY_W;

  logic [DLY_W-1:0] fld [2];
  logic [NW-1:0]    num [2];

  assign fld[0] = out_f;
  assign fld[1] = wp_f;

  // both fields use the same decode: zero selects the full range
  for (genvar g = 0; g < 2; g++) begin : g_dec
    assign num[g] = (fld[g] == '0) ? FULL : {1'b0, fld[g]};
  end

  assign out_n  = num[0];
  assign err    = num[1] < num[0];
  assign wp_eff = err ? num[0] : num[1];
endmodule

// File: rtl/wrs_elapsed.sv
module wrs_elapsed #(
  parameter int unsigned DLY_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wake_i,
  output logic [DLY_W:0] cnt,
  output logic           start
);
  localparam int unsigned NW = DLY_W + 1;
  // the largest threshold is full range plus one set/reset cycle
  localparam logic [NW-1:0] LIM = (NW'(1) << DLY_W) + NW'(1);

  assign start = wake_i && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!wake_i)    cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + NW'(1);
  end
endmodule

// File: rtl/wrs_release.sv
module wrs_release #(
  parameter int unsigned DLY_W = 10
) (
  input  logic [DLY_W:0]     cnt,
  input  logic [DLY_W:0]     out_n,
  input  logic [DLY_W:0]     wp_eff,
  input  logic               gsr_en,
  output wrs_pkg::rel_flags_t flags
);
  localparam int unsigned NW = DLY_W + 1;
  logic [NW-1:0] gwe_thr;

  // the set/reset pulse takes one cycle, so it pushes write enable back one edge
  assign gwe_thr       = wp_eff + {{(NW-1){1'b0}}, gsr_en};
  assign flags.out_rel = (cnt != '0) && (cnt >= out_n);
  assign flags.gwe     = (cnt != '0) && (cnt >= gwe_thr);
  assign flags.gsr     = gsr_en && (cnt == wp_eff);
endmodule

// File: rtl/wake_release_seq.sv
module wake_release_seq #(
  parameter int unsigned DLY_W = wrs_pkg::DLY_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake_i,
  input  logic [DLY_W-1:0] out_dly_i,
  input  logic [DLY_W-1:0] wp_dly_i,
  input  logic             gsr_en_i,
  output logic             out_rel_o,
  output logic             gwe_o,
  output logic             gsr_o,
  output logic             cfg_err_o,
  output logic             done_o
);
  localparam int unsigned NW = DLY_W + 1;

  logic [NW-1:0] cnt;
  logic          start;
  logic [NW-1:0] out_n_d, wp_eff_d;
  logic          err_d;
  logic [NW-1:0] out_q, wp_q;
  logic          err_q, gsr_q;
  wrs_pkg::rel_flags_t flags;

  wrs_elapsed #(.DLY_W(DLY_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .cnt(cnt), .start(start)
  );

  wrs_dly_decode #(.DLY_W(DLY_W)) u_dec (
    .out_f(out_dly_i), .wp_f(wp_dly_i),
    .out_n(out_n_d), .wp_eff(wp_eff_d), .err(err_d)
  );

  // capture the configuration on the first wake edge of each sequence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '1;
      wp_q  <= '1;
      err_q <= 1'b0;
      gsr_q <= 1'b0;
    end else if (start) begin
      out_q <= out_n_d;
      wp_q  <= wp_eff_d;
      err_q <= err_d;
      gsr_q <= gsr_en_i;
    end
  end

  wrs_release #(.DLY_W(DLY_W)) u_rel (
    .cnt(cnt), .out_n(out_q), .wp_eff(wp_q), .gsr_en(gsr_q), .flags(flags)
  );

  assign out_rel_o = flags.out_rel;
  assign gwe_o     = flags.gwe;
  assign gsr_o     = flags.gsr;
  assign cfg_err_o = (cnt != '0) && err_q;
  assign done_o    = flags.out_rel && flags.gwe;
endmodule

// File: rtl/wrs_checker.sv
module wrs_checker (
  input logic clk,
  input logic rst_n,
  input logic wake_i,
  input logic out_rel_o,
  input logic gwe_o,
  input logic gsr_o,
  input logic done_o
);
  p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gwe_o |-> out_rel_o);

  p_gsr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gsr_o |=> !gsr_o);

  p_gsr_then_gwe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gsr_o && wake_i) |=> gwe_o);

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_i |=> (!out_rel_o && !gwe_o && !gsr_o));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && wake_i) |=> done_o);

  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rel_o && wake_i) |=> out_rel_o);
endmodule

bind wake_release_seq wrs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .out_rel_o(out_rel_o),
  .gwe_o(gwe_o), .gsr_o(gsr_o), .done_o(done_o)
);

// File: tb/tb_wake_release_seq.sv
module tb_wake_release_seq;
  localparam int W = 4;
  localparam int CLK_PERIOD = 10;
  localparam int FULL = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake_i = 1'b0;
  logic [W-1:0] out_dly_i = '0;
  logic [W-1:0] wp_dly_i = '0;
  logic gsr_en_i = 1'b0;
  logic out_rel_o, gwe_o, gsr_o, cfg_err_o, done_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_release_seq #(.DLY_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .out_dly_i(out_dly_i),
    .wp_dly_i(wp_dly_i), .gsr_en_i(gsr_en_i), .out_rel_o(out_rel_o),
    .gwe_o(gwe_o), .gsr_o(gsr_o), .cfg_err_o(cfg_err_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual rel/gwe/gsr/err/done=%b expected=%b", req, $time, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {out_rel_o, gwe_o, gsr_o, cfg_err_o, done_o};
  endfunction

  function automatic logic [4:0] model(int k, int no, int nw, bit g);
    int ne;
    logic r, e, s;
    ne = (nw > no) ? nw : no;
    r = (k >= no);
    e = (k >= ne + int'(g));
    s = g && (k == ne);
    return {r, e, s, (k >= 1) && (nw < no), r && e};
  endfunction

  function automatic int dec(int f);
    return (f == 0) ? FULL : f;
  endfunction

  // one sequence: inputs change at negedges, outputs are sampled at negedges
  task automatic run_seq(int o, int w, bit g, string tag);
    int no, nw, ne, len;
    no = dec(o);
    nw = dec(w);
    ne = (nw > no) ? nw : no;
    len = ne + 3;
    out_dly_i = o[W-1:0];
    wp_dly_i = w[W-1:0];
    gsr_en_i = g;
    wake_i = 1'b1;
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      chk(tag, outs(), model(k, no, nw, g));
      if (k == 1) begin
        // R10: configuration changed after capture must be ignored
        out_dly_i = ~out_dly_i;
        wp_dly_i = wp_dly_i + 4'd5;
        gsr_en_i = ~gsr_en_i;
      end
    end
    wake_i = 1'b0;
    @(negedge clk);
    chk("R1 suspend after sequence", outs(), 5'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 in reset", outs(), 5'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle with wake low", outs(), 5'b0);

    // full sweep: R2 R3 R4 R5 R6 R7 R9 R10
    for (int g = 0; g < 2; g++)
      for (int o = 0; o < FULL; o++)
        for (int w = 0; w < FULL; w++)
          run_seq(o, w, g[0], g ? "R6/R2/R5/R9/R10 gsr on" : "R3/R7/R2/R5/R9/R10 gsr off");

    // R8: abort after 3 edges, with delays 6 and 8, gsr on
    out_dly_i = 4'd6; wp_dly_i = 4'd8; gsr_en_i = 1'b1;
    wake_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 pre-abort", outs(), model(3, 6, 8, 1'b1));
    wake_i = 1'b0;
    @(negedge clk);
    chk("R8 abort clears outputs", outs(), 5'b0);
    // R8: abort after the output release, then restart from edge 1
    out_dly_i = 4'd2; wp_dly_i = 4'd3; gsr_en_i = 1'b0;
    wake_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 released before abort", outs(), model(2, 2, 3, 1'b0));
    wake_i = 1'b0;
    @(negedge clk);
    chk("R8 abort after release", outs(), 5'b0);
    run_seq(2, 3, 1'b0, "R8 restart counts from edge 1");

    // R1: reset in the middle of a sequence
    wake_i = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset mid-sequence", outs(), 5'b0);
    wake_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset release", outs(), 5'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule